// File: doc/BRIEF.md
# Quantized-Coefficient DCT Energy Extractor

This block turns one window of `WIN_LEN` signed samples into one spectral feature, the projection of the window onto a single cosine basis function. The cosine weights are coarse: each one is one of eleven signed 4-bit levels. Software picks the frequency offline. It loads two tables. The first says which level group each sample position belongs to. The second holds the eleven level values.

While the window streams in, the block does no multiplication. Each sample goes through the position table and is added to the running sum of its group. After the last sample, one shared multiplier scales each of the eleven group sums by its level over eleven consecutive cycles, and the products are accumulated. The block then emits the signed coefficient. When the square mode bit is set, it emits the coefficient squared, which is the band energy.

A window opens with a sample flagged as a start. A new start flag at any point drops the work in progress and begins a fresh window.

Top module: `qdct_energy`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0 and `res_data` is 0 until a full window has been processed.
- R2: The sample accepted with `s_start` high is position 0, and the next `WIN_LEN-1` accepted samples are positions 1 to `WIN_LEN-1`. In linear mode (`square_en` = 0) the result is the sum over all positions n of x_n · L[G(n)]. G(n) is the 4-bit group code written for position n through `map_we`/`map_idx`/`map_grp`. L[k] is the signed 4-bit level written for group k through `lvl_we`/`lvl_sel`/`lvl_val`. Both tables reset to all zeros.
- R3: The result is exact for any legal input. This includes every sample at full-scale negative or positive in one group whose level is -8.
- R4: `res_valid` rises on the 11th rising clock edge after the edge that accepted sample `WIN_LEN-1`, and it stays high for exactly one cycle.
- R5: When `square_en` is 1 on the edge that produces the result, `res_data` is the square of the linear result, which is never negative.
- R6: A start flag arriving before a window has received all its samples discards the partial window. The result then reflects only the samples from the new start.
- R7: A start flag arriving during the eleven-cycle multiply phase cancels that result, so no `res_valid` pulse is produced for it.
- R8: Samples presented without a start flag while no window is open are ignored. They produce no result and do not affect the next window.
- R9: A position whose group code is 11 or above contributes nothing to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Write strobe for the position-to-group table |
| map_idx | input | IDX_W | Sample position to write |
| map_grp | input | 4 | Group code for that position |
| lvl_we | input | 1 | Write strobe for the level table |
| lvl_sel | input | 4 | Group whose level is written |
| lvl_val | input | 4 | Signed level value |
| square_en | input | 1 | 1 selects squared (energy) output |
| s_valid | input | 1 | Sample present |
| s_start | input | 1 | Sample is position 0 of a new window |
| s_data | input | SAMP_W | Signed sample |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Signed result, linear sign-extended or squared |

## Verification
The checker assumes that `square_en` is steady around the edge that produces a result and that table writes do not overlap an open window. The bench changes the mode bit and the tables only while the block is idle, so these assumptions always hold. The checker also relies on the samples and levels being two's-complement values within their declared widths. The linear-range property depends on that. The bench keeps every generated sample inside the 12-bit signed range. Its full-scale test uses the exact extremes of that range and the most negative level.

// File: rtl/qdct_pkg.sv
package qdct_pkg;

    // Eleven quantized cosine levels, each a signed 4-bit value.
    localparam int NUM_LVL = 11;
    localparam int LVL_W   = 4;
    localparam int GRP_W   = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACC  = 2'd1,
        PH_MUL  = 2'd2
    } phase_e;

    function automatic int bits_for(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/qdct_group_map.sv
module qdct_group_map
    import qdct_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [GRP_W-1:0] rd_grp
);

    logic [GRP_W-1:0] tbl_q [WIN_LEN];

    for (genvar i = 0; i < WIN_LEN; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                tbl_q[i] <= wr_grp;
            end
        end
    end

    always_comb begin
        rd_grp = '0;
        for (int i = 0; i < WIN_LEN; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_grp = tbl_q[i];
            end
        end
    end

endmodule

// File: rtl/qdct_level_bank.sv
module qdct_level_bank
    import qdct_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [GRP_W-1:0]                  wr_sel,
    input  logic [LVL_W-1:0]                  wr_val,
    output logic [NUM_LVL-1:0][LVL_W-1:0]     levels
);

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                levels[k] <= '0;
            end else if (wr_en && wr_sel == GRP_W'(k)) begin
                levels[k] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/qdct_group_acc.sv
module qdct_group_acc
    import qdct_pkg::*;
#(
    parameter int SAMP_W = 12,
    parameter int ACC_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clear,
    input  logic                              add,
    input  logic [GRP_W-1:0]                  grp,
    input  logic signed [SAMP_W-1:0]          sample,
    output logic [NUM_LVL-1:0][ACC_W-1:0]     sums
);

    localparam int EXT_W = ACC_W - SAMP_W;

    logic [ACC_W-1:0] sample_ext;
    assign sample_ext = {{EXT_W{sample[SAMP_W-1]}}, sample};

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_bin
        logic hit;
        assign hit = add && (grp == GRP_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                sums[g] <= '0;
            end else if (clear) begin
                sums[g] <= hit ? sample_ext : '0;
            end else if (hit) begin
                sums[g] <= sums[g] + sample_ext;
            end
        end
    end

endmodule

// File: rtl/qdct_mac_seq.sv
module qdct_mac_seq
    import qdct_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int SUM_W = 24,
    parameter int RES_W = 48
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              step,
    input  logic                              first,
    input  logic                              last,
    input  logic                              square_en,
    input  logic [GRP_W-1:0]                  k,
    input  logic [NUM_LVL-1:0][ACC_W-1:0]     sums,
    input  logic [NUM_LVL-1:0][LVL_W-1:0]     levels,
    output logic                              res_valid,
    output logic signed [RES_W-1:0]           res_data
);

    localparam int PROD_W = ACC_W + LVL_W;

    logic [ACC_W-1:0]         sel_sum;
    logic [LVL_W-1:0]         sel_lvl;
    logic signed [PROD_W-1:0] ext_sum;
    logic signed [PROD_W-1:0] ext_lvl;
    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  prod_ext;
    logic signed [SUM_W-1:0]  total_q;
    logic signed [SUM_W-1:0]  total_nxt;
    logic signed [RES_W-1:0]  lin_ext;
    logic signed [RES_W-1:0]  sq;

    // One shared multiplier: the group counter picks the operand pair.
    always_comb begin
        sel_sum = '0;
        sel_lvl = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (k == GRP_W'(i)) begin
                sel_sum = sums[i];
                sel_lvl = levels[i];
            end
        end
    end

    assign ext_sum   = $signed({{LVL_W{sel_sum[ACC_W-1]}}, sel_sum});
    assign ext_lvl   = $signed({{ACC_W{sel_lvl[LVL_W-1]}}, sel_lvl});
    assign prod      = ext_sum * ext_lvl;
    assign prod_ext  = $signed({{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod});
    assign total_nxt = first ? prod_ext : total_q + prod_ext;
    assign lin_ext   = $signed({{(RES_W-SUM_W){total_nxt[SUM_W-1]}}, total_nxt});
    assign sq        = lin_ext * lin_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q   <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (step) begin
                total_q <= total_nxt;
                if (last) begin
                    res_valid <= 1'b1;
                    res_data  <= square_en ? sq : lin_ext;
                end
            end
        end
    end

endmodule

// File: rtl/qdct_energy.sv
module qdct_energy
    import qdct_pkg::*;
#(
    parameter int SAMP_W  = 12,
    parameter int WIN_LEN = 16,
    parameter int IDX_W   = bits_for(WIN_LEN),
    parameter int ACC_W   = SAMP_W + bits_for(WIN_LEN),
    parameter int SUM_W   = ACC_W + LVL_W + bits_for(NUM_LVL),
    parameter int RES_W   = 2 * SUM_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     map_we,
    input  logic [IDX_W-1:0]         map_idx,
    input  logic [GRP_W-1:0]         map_grp,
    input  logic                     lvl_we,
    input  logic [GRP_W-1:0]         lvl_sel,
    input  logic [LVL_W-1:0]         lvl_val,
    input  logic                     square_en,
    input  logic                     s_valid,
    input  logic                     s_start,
    input  logic signed [SAMP_W-1:0] s_data,
    output logic                     res_valid,
    output logic signed [RES_W-1:0]  res_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);
    localparam logic [GRP_W-1:0] LAST_K   = GRP_W'(NUM_LVL - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [GRP_W-1:0] k_q;
    logic             take_start;
    logic             take_next;
    logic [IDX_W-1:0] rd_idx;
    logic [GRP_W-1:0] cur_grp;
    logic             mul_step;

    logic [NUM_LVL-1:0][ACC_W-1:0] grp_sums;
    logic [NUM_LVL-1:0][LVL_W-1:0] levels;

    assign take_start = s_valid && s_start;
    assign take_next  = s_valid && !s_start && (phase_q == PH_ACC);
    assign rd_idx     = take_start ? '0 : idx_q;
    assign mul_step   = (phase_q == PH_MUL) && !take_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            k_q     <= '0;
        end else if (take_start) begin
            phase_q <= PH_ACC;
            idx_q   <= IDX_W'(1);
        end else begin
            unique case (phase_q)
                PH_ACC: begin
                    if (take_next) begin
                        if (idx_q == LAST_IDX) begin
                            phase_q <= PH_MUL;
                            k_q     <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                PH_MUL: begin
                    if (k_q == LAST_K) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        k_q <= k_q + GRP_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    qdct_group_map #(.WIN_LEN(WIN_LEN), .IDX_W(IDX_W)) u_map (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (map_we),
        .wr_idx (map_idx),
        .wr_grp (map_grp),
        .rd_idx (rd_idx),
        .rd_grp (cur_grp)
    );

    qdct_level_bank u_lvl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (lvl_we),
        .wr_sel (lvl_sel),
        .wr_val (lvl_val),
        .levels (levels)
    );

    qdct_group_acc #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (take_start),
        .add    (take_start || take_next),
        .grp    (cur_grp),
        .sample (s_data),
        .sums   (grp_sums)
    );

    qdct_mac_seq #(.ACC_W(ACC_W), .SUM_W(SUM_W), .RES_W(RES_W)) u_mac (
        .clk       (clk),
        .rst       (rst),
        .step      (mul_step),
        .first     (k_q == '0),
        .last      (k_q == LAST_K),
        .square_en (square_en),
        .k         (k_q),
        .sums      (grp_sums),
        .levels    (levels),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

endmodule

// File: rtl/qdct_energy_chk.sv
module qdct_energy_chk #(
    parameter int SUM_W = 24,
    parameter int RES_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             s_valid,
    input logic             s_start,
    input logic             square_en,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data
);

    localparam int TOP_BITS = RES_W - SUM_W + 1;

    // R4: result strobe lasts a single cycle
    p_one_cycle_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R7: a start flag on an edge never coincides with a result strobe after it
    p_start_cancels_r7: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_start) |=> !res_valid);

    // R3: linear output never exceeds the coefficient range
    p_linear_fits_r3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(square_en)) |->
            ($countones(res_data[RES_W-1:SUM_W-1]) == 0 ||
             $countones(res_data[RES_W-1:SUM_W-1]) == TOP_BITS));

    // R5: squared output is never negative
    p_square_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(square_en)) |-> !res_data[RES_W-1]);

endmodule

bind qdct_energy qdct_energy_chk #(.SUM_W(SUM_W), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .s_start   (s_start),
    .square_en (square_en),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/qdct_energy_test.sv
module qdct_energy_test;

    localparam int SAMP_W  = 12;
    localparam int WIN_LEN = 16;
    localparam int IDX_W   = 4;
    localparam int NLVL    = 11;
    localparam int SUM_W   = 24;
    localparam int RES_W   = 48;

    // pattern, parameter, square mode
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{0, 100, 0},
        '{1, 2047, 0},
        '{2, -7, 1},
        '{3, 17, 0},
        '{3, 991, 1},
        '{0, 55, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic map_we = 1'b0;
    logic [IDX_W-1:0] map_idx = '0;
    logic [3:0] map_grp = '0;
    logic lvl_we = 1'b0;
    logic [3:0] lvl_sel = '0;
    logic [3:0] lvl_val = '0;
    logic square_en = 1'b0;
    logic s_valid = 1'b0;
    logic s_start = 1'b0;
    logic signed [SAMP_W-1:0] s_data = '0;
    logic res_valid;
    logic signed [RES_W-1:0] res_data;

    int errors = 0;
    int checks = 0;
    int valid_cnt = 0;
    int grp_m [WIN_LEN];
    int lvl_m [NLVL];

    always #5 clk = ~clk;

    qdct_energy #(.SAMP_W(SAMP_W), .WIN_LEN(WIN_LEN)) uut (
        .clk(clk), .rst(rst),
        .map_we(map_we), .map_idx(map_idx), .map_grp(map_grp),
        .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_val(lvl_val),
        .square_en(square_en),
        .s_valid(s_valid), .s_start(s_start), .s_data(s_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    always @(negedge clk) if (!rst && res_valid) valid_cnt++;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int pat, input int p, input int n);
        int v;
        case (pat)
            0: return p * n - 1000;
            1: return (n % 2 == 1) ? p : -p;
            2: return p;
            default: begin
                v = p;
                for (int i = 0; i <= n; i++) v = v * 1103515245 + 12345;
                return (v >>> 8) % 2048;
            end
        endcase
    endfunction

    function automatic longint expect_x(input int pat, input int p, input bit sq);
        longint x = 0;
        for (int n = 0; n < WIN_LEN; n++)
            if (grp_m[n] < NLVL) x += longint'(gen(pat, p, n)) * lvl_m[grp_m[n]];
        return sq ? x * x : x;
    endfunction

    task automatic set_lvl(input int k, input int v);
        lvl_we = 1'b1; lvl_sel = 4'(k); lvl_val = 4'(v);
        @(negedge clk);
        lvl_we = 1'b0;
        lvl_m[k] = v;
    endtask

    task automatic set_grp(input int n, input int g);
        map_we = 1'b1; map_idx = IDX_W'(n); map_grp = 4'(g);
        @(negedge clk);
        map_we = 1'b0;
        grp_m[n] = g;
    endtask

    task automatic drive_window(input int pat, input int p, input int count);
        for (int n = 0; n < count; n++) begin
            s_valid = 1'b1;
            s_start = (n == 0);
            s_data  = SAMP_W'(gen(pat, p, n));
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_start = 1'b0;
    endtask

    // Called at the negedge just after the edge that took the last sample.
    task automatic await_result(input longint exp, input string req);
        bit early = 1'b0;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            if (c < 11 && res_valid) early = 1'b1;
            if (c == 11) begin
                check(res_valid && !early, "R4 latency", longint'(res_valid), 1);
                check(res_data == exp, req, longint'(res_data), exp);
            end
            if (c == 12) check(!res_valid, "R4 pulse", longint'(res_valid), 0);
        end
    endtask

    task automatic run_vec(input int pat, input int p, input bit sq, input string req);
        square_en = sq;
        drive_window(pat, p, WIN_LEN);
        await_result(expect_x(pat, p, sq), req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v0;
        for (int n = 0; n < WIN_LEN; n++) grp_m[n] = 0;
        for (int k = 0; k < NLVL; k++) lvl_m[k] = 0;

        repeat (3) @(negedge clk);
        check(!res_valid, "R1 valid in reset", longint'(res_valid), 0);
        check(res_data == 0, "R1 data in reset", longint'(res_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!res_valid && res_data == 0, "R1 after reset", longint'(res_data), 0);

        // Zeroed tables give a zero result (R2)
        run_vec(3, 5, 1'b0, "R2 zero tables");

        for (int k = 0; k < NLVL; k++) set_lvl(k, k - 5);
        for (int n = 0; n < WIN_LEN; n++) set_grp(n, n % NLVL);

        // R2 and R5 over the vector table
        for (int i = 0; i < NVEC; i++)
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2] != 0,
                    (VEC[i][2] != 0) ? "R5 squared" : "R2 linear");

        // R2: new level takes effect in the next window
        set_lvl(4, 7);
        run_vec(0, 100, 1'b0, "R2 reloaded level");

        // R9: out-of-range group code excluded
        set_grp(3, 15);
        run_vec(2, 1000, 1'b0, "R9 code above ten");
        set_grp(3, 3);

        // R6: restart mid-window
        v0 = valid_cnt;
        square_en = 1'b0;
        drive_window(2, 999, 5);
        check(valid_cnt == v0, "R6 no partial result", valid_cnt - v0, 0);
        drive_window(0, 100, WIN_LEN);
        await_result(expect_x(0, 100, 1'b0), "R6 restarted window");

        // R7: start during multiply phase
        v0 = valid_cnt;
        drive_window(3, 17, WIN_LEN);
        repeat (5) @(negedge clk);
        drive_window(1, 2047, WIN_LEN);
        check(valid_cnt == v0, "R7 cancelled result", valid_cnt - v0, 0);
        await_result(expect_x(1, 2047, 1'b0), "R7 following window");

        // R8: stray samples while idle
        v0 = valid_cnt;
        for (int n = 0; n < 6; n++) begin
            s_valid = 1'b1; s_start = 1'b0; s_data = 12'sd2000;
            @(negedge clk);
        end
        s_valid = 1'b0;
        repeat (15) @(negedge clk);
        check(valid_cnt == v0, "R8 no result from idle samples", valid_cnt - v0, 0);
        run_vec(3, 17, 1'b0, "R8 next window intact");

        // R3: full-scale samples, one group, level -8
        for (int n = 0; n < WIN_LEN; n++) set_grp(n, 0);
        set_lvl(0, -8);
        run_vec(2, -2048, 1'b0, "R3 full-scale negative");
        check(expect_x(2, -2048, 1'b0) == 262144, "R3 reference", expect_x(2, -2048, 1'b0), 262144);
        run_vec(2, 2047, 1'b1, "R3 full-scale positive squared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule